// File: doc/BRIEF.md
# Banked Internal Data RAM Controller

This block owns a 128-byte on-chip data RAM and turns every kind of internal data access into one physical byte address. A caller names a working register (index 0 to 7) within one of four banks, gives a full 8-bit direct address, or points indirectly through the first or second working register of the active bank. The block also keeps an 8-bit stack pointer for push and pop, and it can swap the low nibble of an accumulator value with the low nibble of an indirectly addressed byte.

The working registers occupy the bottom 32 bytes as four groups of eight. The 16 bytes above them and the 80 scratch bytes up to 7Fh are reached by direct, indirect or stack access. Nothing above 7Fh exists in this RAM. Each operation is sampled on one clock edge. Its result shows on registered outputs after that edge: read data, the new accumulator value, a write strobe with its address, the stack pointer and a stack range error.

Top module: `bank_ram_ctrl`

## Requirements
- R1: After reset, every RAM byte reads as 00h, the stack pointer reads 07h, and rdata_o, acc_o, wr_o, wr_addr_o and stk_err_o are all zero.
- R2: A register access (op_i 1 = read, 2 = write) uses physical address bank_i × 8 + reg_idx_i. With bank 0 active, register n and direct address n are the same byte.
- R3: A direct access (op_i 3 = read, 4 = write) uses dir_addr_i. An address at or above 80h reads as 00h, and a write to it changes no byte and raises no strobe.
- R4: An indirect access (op_i 5 = read, 6 = write) takes its address from the byte held in register 0 (ptr_sel_i = 0) or register 1 (ptr_sel_i = 1) of the active bank. A pointer at or above 80h reads as 00h and writes nothing.
- R5: Push (op_i 7) first increments the stack pointer and then writes wdata_i at the new pointer value.
- R6: Pop (op_i 8) returns the byte at the current stack pointer on rdata_o and then decrements the pointer.
- R7: The stack pointer wraps modulo 256. A push or pop whose target is above 7Fh sets stk_err_o for one cycle, writes nothing, returns 00h for a pop, and still moves the pointer.
- R8: Nibble exchange (op_i 9) addresses a byte as an indirect access does. acc_o becomes {acc_i[7:4], byte[3:0]} and the byte becomes {byte[7:4], acc_i[3:0]}. With a pointer above 7Fh, acc_o equals acc_i and nothing is written.
- R9: wr_o is high for exactly the cycle after a write into the RAM, and wr_addr_o then holds the address written. After any other operation wr_o is low.
- R10: Results appear on the outputs after the clock edge that samples op_i. With op_i 0 (or any unused code 10 to 15), the RAM and the stack pointer are unchanged, and rdata_o and acc_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code, see R2 to R10 |
| bank_i | input | 2 | Active register bank |
| reg_idx_i | input | 3 | Working register index |
| dir_addr_i | input | 8 | Direct byte address |
| ptr_sel_i | input | 1 | Pointer register for indirect access: 0 = register 0, 1 = register 1 |
| wdata_i | input | 8 | Write data for register, direct, indirect and push writes |
| acc_i | input | 8 | Accumulator value for nibble exchange |
| rdata_o | output | 8 | Read data from the last read-type operation |
| acc_o | output | 8 | Accumulator result from the last nibble exchange |
| wr_o | output | 1 | Write strobe for the previous cycle's RAM write |
| wr_addr_o | output | 8 | Address of that write |
| sp_o | output | 8 | Stack pointer |
| stk_err_o | output | 1 | Stack access fell outside the RAM |

## Verification
The same register index is written under each of the four bank selects and read back directly. This separates a correct bank × 8 offset from a mapping that ignores the bank or shifts it wrongly. Indirect accesses go through both pointer registers in two different banks, and also through a pointer above 7Fh, so that the bench can tell a pointer fetched from the wrong register or bank apart from correct decoding. A run of pushes fills the stack up to the top of the RAM and then past it, and pops bring the pointer down past zero. This run shows the increment-then-write and read-then-decrement ordering, the error at 80h and the wrap to FFh. Nibble exchange is tried with distinct values in each nibble, so that any swap of the upper nibbles becomes visible.

// File: rtl/bram_pkg.sv
package bram_pkg;
  localparam int DW = 8;
  localparam int AW = 8;

  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_REG_RD = 4'd1,
    OP_REG_WR = 4'd2,
    OP_DIR_RD = 4'd3,
    OP_DIR_WR = 4'd4,
    OP_IND_RD = 4'd5,
    OP_IND_WR = 4'd6,
    OP_PUSH   = 4'd7,
    OP_POP    = 4'd8,
    OP_XCHD   = 4'd9
  } bram_op_e;

  // physical byte for a working register: bank * 8 + index
  function automatic logic [AW-1:0] bank_reg_addr(input logic [1:0] bank,
                                                  input logic [2:0] idx);
    return {3'b000, bank, idx};
  endfunction

  function automatic logic in_ram(input logic [AW-1:0] a, input int depth);
    return int'(a) < depth;
  endfunction

  // returns {new accumulator, new memory byte}
  function automatic logic [2*DW-1:0] nibble_swap(input logic [DW-1:0] acc,
                                                  input logic [DW-1:0] mem);
    return {acc[7:4], mem[3:0], mem[7:4], acc[3:0]};
  endfunction
endpackage

// File: rtl/bram_store.sv
module bram_store
  import bram_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_data,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_data,
  input  logic          we,
  input  logic [AW-1:0] w_addr,
  input  logic [DW-1:0] w_data
);
  localparam int MAW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && in_ram(w_addr, DEPTH)) begin
      mem[w_addr[MAW-1:0]] <= w_data;
    end
  end

  always_comb begin
    a_data = in_ram(a_addr, DEPTH) ? mem[a_addr[MAW-1:0]] : '0;
    b_data = in_ram(b_addr, DEPTH) ? mem[b_addr[MAW-1:0]] : '0;
  end

  // the resolver must never request a write outside the array
  p_write_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> in_ram(w_addr, DEPTH));
endmodule

// File: rtl/bram_stack.sv
module bram_stack
  import bram_pkg::*;
#(
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_inc
);
  assign sp_inc = sp_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp_q <= SP_RESET;
    else if (push) sp_q <= sp_inc;
    else if (pop)  sp_q <= sp_q - 1'b1;
  end

  p_sp_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == $past(sp_q) + 8'd1);
  p_sp_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sp_q == $past(sp_q) - 8'd1);
  p_sp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(sp_q));
endmodule

// File: rtl/bram_resolve.sv
module bram_resolve
  import bram_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  bram_op_e      op,
  input  logic [1:0]    bank,
  input  logic [2:0]    idx,
  input  logic [AW-1:0] dir,
  input  logic          ptr_sel,
  input  logic [DW-1:0] ptr_val,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] sp_inc,
  output logic [AW-1:0] ptr_addr,
  output logic [AW-1:0] tgt_addr,
  output logic          tgt_ok,
  output logic          rd_op,
  output logic          do_wr,
  output logic          stk_bad
);
  logic wr_op;
  logic stk_op;

  always_comb begin
    ptr_addr = bank_reg_addr(bank, {2'b00, ptr_sel});
    unique case (op)
      OP_REG_RD, OP_REG_WR:         tgt_addr = bank_reg_addr(bank, idx);
      OP_DIR_RD, OP_DIR_WR:         tgt_addr = dir;
      OP_IND_RD, OP_IND_WR, OP_XCHD: tgt_addr = ptr_val;
      OP_PUSH:                      tgt_addr = sp_inc;
      OP_POP:                       tgt_addr = sp;
      default:                      tgt_addr = '0;
    endcase
    tgt_ok  = in_ram(tgt_addr, DEPTH);
    rd_op   = op inside {OP_REG_RD, OP_DIR_RD, OP_IND_RD, OP_POP};
    wr_op   = op inside {OP_REG_WR, OP_DIR_WR, OP_IND_WR, OP_PUSH, OP_XCHD};
    stk_op  = op inside {OP_PUSH, OP_POP};
    do_wr   = wr_op && tgt_ok;
    stk_bad = stk_op && !tgt_ok;
  end
endmodule

// File: rtl/bank_ram_ctrl.sv
module bank_ram_ctrl
  import bram_pkg::*;
#(
  parameter int            DEPTH    = 128,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic [1:0]    bank_i,
  input  logic [2:0]    reg_idx_i,
  input  logic [AW-1:0] dir_addr_i,
  input  logic          ptr_sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] acc_o,
  output logic          wr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] sp_o,
  output logic          stk_err_o
);
  bram_op_e      op;
  logic [AW-1:0] ptr_addr, tgt_addr, sp_q, sp_inc;
  logic [DW-1:0] ptr_val, tgt_data, wr_data;
  logic [2*DW-1:0] swapped;
  logic          tgt_ok, rd_op, do_wr, stk_bad;

  assign op = bram_op_e'(op_i);

  bram_stack #(.SP_RESET(SP_RESET)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(op == OP_PUSH), .pop(op == OP_POP),
    .sp_q(sp_q), .sp_inc(sp_inc)
  );

  bram_resolve #(.DEPTH(DEPTH)) u_resolve (
    .op(op), .bank(bank_i), .idx(reg_idx_i), .dir(dir_addr_i),
    .ptr_sel(ptr_sel_i), .ptr_val(ptr_val), .sp(sp_q), .sp_inc(sp_inc),
    .ptr_addr(ptr_addr), .tgt_addr(tgt_addr), .tgt_ok(tgt_ok),
    .rd_op(rd_op), .do_wr(do_wr), .stk_bad(stk_bad)
  );

  assign swapped = nibble_swap(acc_i, tgt_data);
  assign wr_data = (op == OP_XCHD) ? swapped[DW-1:0] : wdata_i;

  bram_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_addr(ptr_addr), .a_data(ptr_val),
    .b_addr(tgt_addr), .b_data(tgt_data),
    .we(do_wr), .w_addr(tgt_addr), .w_data(wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o   <= '0;
      acc_o     <= '0;
      wr_o      <= 1'b0;
      wr_addr_o <= '0;
      stk_err_o <= 1'b0;
    end else begin
      if (rd_op) rdata_o <= tgt_ok ? tgt_data : '0;
      if (op == OP_XCHD) acc_o <= tgt_ok ? swapped[2*DW-1:DW] : acc_i;
      wr_o      <= do_wr;
      wr_addr_o <= do_wr ? tgt_addr : '0;
      stk_err_o <= stk_bad;
    end
  end

  assign sp_o = sp_q;

  p_err_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err_o |-> !wr_o);
  p_push_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && sp_q < 8'h7F) |=> wr_o && wr_addr_o == sp_o);
  p_dir_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DIR_RD && dir_addr_i[7]) |=> rdata_o == 8'h00);
  p_xchd_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XCHD) |=> acc_o[7:4] == $past(acc_i[7:4]));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> !wr_o && !stk_err_o);
endmodule

// File: tb/sim_bank_ram_ctrl.sv
`timescale 1ns/1ps
module sim_bank_ram_ctrl;
  localparam logic [3:0] IDLE = 4'd0, RRD = 4'd1, RWR = 4'd2, DRD = 4'd3,
    DWR = 4'd4, IRD = 4'd5, IWR = 4'd6, PSH = 4'd7, POPC = 4'd8, XCH = 4'd9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [1:0] bank_i = '0;
  logic [2:0] reg_idx_i = '0;
  logic [7:0] dir_addr_i = '0, wdata_i = '0, acc_i = '0;
  logic ptr_sel_i = 1'b0;
  logic [7:0] rdata_o, acc_o, wr_addr_o, sp_o;
  logic wr_o, stk_err_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bank_ram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .bank_i(bank_i),
    .reg_idx_i(reg_idx_i), .dir_addr_i(dir_addr_i), .ptr_sel_i(ptr_sel_i),
    .wdata_i(wdata_i), .acc_i(acc_i), .rdata_o(rdata_o), .acc_o(acc_o),
    .wr_o(wr_o), .wr_addr_o(wr_addr_o), .sp_o(sp_o), .stk_err_o(stk_err_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // drive one operation for one edge; outputs are sampled at the following negedge
  task automatic run(input logic [3:0] op, input logic [1:0] bk, input logic [2:0] ix,
                     input logic [7:0] da, input logic ps, input logic [7:0] wd,
                     input logic [7:0] ac);
    @(negedge clk);
    op_i = op; bank_i = bk; reg_idx_i = ix; dir_addr_i = da;
    ptr_sel_i = ps; wdata_i = wd; acc_i = ac;
    @(negedge clk);
    op_i = IDLE;
  endtask

  task automatic dir_rd(input logic [7:0] a);
    run(DRD, 2'd0, 3'd0, a, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic t_reset;
    chk("R1 sp", sp_o, 8'h07);
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 acc", acc_o, 8'h00);
    chk("R1 wr", {7'd0, wr_o}, 8'h00);
    chk("R1 err", {7'd0, stk_err_o}, 8'h00);
    run(DWR, 2'd0, 3'd0, 8'h10, 1'b0, 8'hFF, 8'h00);  // write then read elsewhere
    dir_rd(8'h2A);
    chk("R1 ram cleared", rdata_o, 8'h00);
  endtask

  task automatic t_banks;
    for (int b = 0; b < 4; b++) begin
      run(RWR, 2'(b), 3'd5, 8'h00, 1'b0, 8'hA0 + 8'(b), 8'h00);
      chk("R9 strobe", {7'd0, wr_o}, 8'h01);
      chk("R2 wr addr", wr_addr_o, 8'(b * 8 + 5));
    end
    for (int b = 0; b < 4; b++) begin
      dir_rd(8'(b * 8 + 5));
      chk("R2 bank byte", rdata_o, 8'hA0 + 8'(b));
      chk("R9 no strobe on read", {7'd0, wr_o}, 8'h00);
    end
    run(RRD, 2'd2, 3'd5, 8'h00, 1'b0, 8'h00, 8'h00);
    chk("R2 reg read", rdata_o, 8'hA2);
    run(DWR, 2'd0, 3'd0, 8'h03, 1'b0, 8'h6E, 8'h00);
    run(RRD, 2'd0, 3'd3, 8'h00, 1'b0, 8'h00, 8'h00);
    chk("R2 bank0 alias", rdata_o, 8'h6E);
  endtask

  task automatic t_direct;
    run(DWR, 2'd0, 3'd0, 8'h7F, 1'b0, 8'h55, 8'h00);
    chk("R3 top write strobe", wr_addr_o, 8'h7F);
    dir_rd(8'h7F);
    chk("R3 top byte", rdata_o, 8'h55);
    run(DWR, 2'd0, 3'd0, 8'h80, 1'b0, 8'h99, 8'h00);
    chk("R3 high write no strobe", {7'd0, wr_o}, 8'h00);
    dir_rd(8'h80);
    chk("R3 high read zero", rdata_o, 8'h00);
    dir_rd(8'h00);
    chk("R3 no alias to 00", rdata_o, 8'h00);
  endtask

  task automatic t_indirect;
    run(RWR, 2'd1, 3'd0, 8'h00, 1'b0, 8'h40, 8'h00);
    run(RWR, 2'd1, 3'd1, 8'h00, 1'b0, 8'h41, 8'h00);
    run(IWR, 2'd1, 3'd0, 8'h00, 1'b0, 8'h9C, 8'h00);
    chk("R4 via reg0 addr", wr_addr_o, 8'h40);
    run(IWR, 2'd1, 3'd0, 8'h00, 1'b1, 8'h3D, 8'h00);
    chk("R4 via reg1 addr", wr_addr_o, 8'h41);
    dir_rd(8'h40);
    chk("R4 byte 40", rdata_o, 8'h9C);
    run(IRD, 2'd1, 3'd0, 8'h00, 1'b1, 8'h00, 8'h00);
    chk("R4 read via reg1", rdata_o, 8'h3D);
    run(RWR, 2'd0, 3'd1, 8'h00, 1'b0, 8'h90, 8'h00);
    run(IWR, 2'd0, 3'd0, 8'h00, 1'b1, 8'h77, 8'h00);
    chk("R4 high pointer no strobe", {7'd0, wr_o}, 8'h00);
    run(IRD, 2'd0, 3'd0, 8'h00, 1'b1, 8'h00, 8'h00);
    chk("R4 high pointer reads zero", rdata_o, 8'h00);
  endtask

  task automatic t_xchd;
    run(RWR, 2'd2, 3'd0, 8'h00, 1'b0, 8'h30, 8'h00);
    run(DWR, 2'd0, 3'd0, 8'h30, 1'b0, 8'hB6, 8'h00);
    run(XCH, 2'd2, 3'd0, 8'h00, 1'b0, 8'h00, 8'h4F);
    chk("R8 acc result", acc_o, 8'h46);
    chk("R8 strobe addr", wr_addr_o, 8'h30);
    dir_rd(8'h30);
    chk("R8 byte result", rdata_o, 8'hBF);
    run(RWR, 2'd2, 3'd1, 8'h00, 1'b0, 8'hA0, 8'h00);
    run(XCH, 2'd2, 3'd0, 8'h00, 1'b1, 8'h00, 8'h12);
    chk("R8 high pointer acc", acc_o, 8'h12);
    chk("R8 high pointer no strobe", {7'd0, wr_o}, 8'h00);
  endtask

  task automatic t_idle;
    logic [7:0] sp0, rd0, ac0;
    sp0 = sp_o; rd0 = rdata_o; ac0 = acc_o;
    run(IDLE, 2'd3, 3'd7, 8'h20, 1'b1, 8'hEE, 8'hEE);
    run(4'd12, 2'd3, 3'd7, 8'h20, 1'b1, 8'hEE, 8'hEE);
    chk("R10 sp held", sp_o, sp0);
    chk("R10 rdata held", rdata_o, rd0);
    chk("R10 acc held", acc_o, ac0);
    chk("R10 no strobe", {7'd0, wr_o}, 8'h00);
    dir_rd(8'h20);
    chk("R10 ram untouched", rdata_o, 8'h00);
  endtask

  task automatic t_stack;
    run(PSH, 2'd0, 3'd0, 8'h00, 1'b0, 8'h11, 8'h00);
    chk("R5 sp after push", sp_o, 8'h08);
    chk("R5 push addr", wr_addr_o, 8'h08);
    run(PSH, 2'd0, 3'd0, 8'h00, 1'b0, 8'h22, 8'h00);
    chk("R5 sp second", sp_o, 8'h09);
    dir_rd(8'h09);
    chk("R5 pushed byte", rdata_o, 8'h22);
    run(POPC, 2'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00);
    chk("R6 pop data", rdata_o, 8'h22);
    chk("R6 sp after pop", sp_o, 8'h08);
    run(POPC, 2'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00);
    chk("R6 pop data 2", rdata_o, 8'h11);
    chk("R6 sp back", sp_o, 8'h07);
  endtask

  task automatic t_wrap;
    int bad = 0;
    for (int a = 8; a < 128; a++) run(PSH, 2'd0, 3'd0, 8'h00, 1'b0, 8'(a) ^ 8'hC3, 8'h00);
    chk("R7 sp at top", sp_o, 8'h7F);
    run(PSH, 2'd0, 3'd0, 8'h00, 1'b0, 8'hEE, 8'h00);
    chk("R7 sp past top", sp_o, 8'h80);
    chk("R7 push error", {7'd0, stk_err_o}, 8'h01);
    chk("R7 push no strobe", {7'd0, wr_o}, 8'h00);
    run(POPC, 2'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00);
    chk("R7 pop error", {7'd0, stk_err_o}, 8'h01);
    chk("R7 pop zero", rdata_o, 8'h00);
    for (int a = 127; a >= 8; a--) begin
      run(POPC, 2'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00);
      if (rdata_o !== (8'(a) ^ 8'hC3) || stk_err_o !== 1'b0) bad++;
    end
    chk("R6 stack drain order", 8'(bad), 8'h00);
    for (int a = 7; a >= 0; a--) run(POPC, 2'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00);
    chk("R7 wrap below zero", sp_o, 8'hFF);
    chk("R7 pop at 00 no error", {7'd0, stk_err_o}, 8'h00);
    run(PSH, 2'd0, 3'd0, 8'h00, 1'b0, 8'h5A, 8'h00);
    chk("R7 wrap to zero", sp_o, 8'h00);
    chk("R7 push at 00 addr", wr_addr_o, 8'h00);
    dir_rd(8'h00);
    chk("R7 byte at 00", rdata_o, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_banks();
    t_direct();
    t_indirect();
    t_xchd();
    t_idle();
    t_stack();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule